// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block is the interrupt front end of a small microcontroller core. It watches two active-low external request pins, two timer overflow strobes and a group of three internal events (a third timer overflow, a time-base tick and a real-time flag) that share one combined request. Each source has an enable bit and a request flag. A global master enable gates all of them. The CPU reaches these bits through a byte-wide register port with three addresses.

Every cycle the block checks the pending sources, meaning those whose flag and enable are both set. It takes the one with the highest fixed priority, provided the master enable is set and the core reports room on its call stack. When it takes an interrupt it pulses an acknowledge for one cycle and presents a word-aligned vector address. In the same clock edge it clears the taken source's flag and clears the master enable, so no further interrupt is taken until software sets the master enable again.

The external pins are synchronised and edge-detected inside the block. A pin held low produces exactly one request. Software can set or clear any flag through the register port. A hardware event that arrives in the same cycle as a software clear still sets the flag.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high-to-low transition on `ext_irq_n_i[0]` or `ext_irq_n_i[1]` sets the matching external request flag after a two-flop synchronizer. Holding the pin low does not set the flag again after software clears it, and a low-to-high transition sets nothing.
- R2: Register address 0 (control 0) holds: bit 0 master enable, bit 1 external 0 enable, bit 2 external 1 enable, bit 3 timer 0 enable, bit 4 external 0 flag, bit 5 external 1 flag, bit 6 timer 0 flag (set by `tmr0_ovf_i`), bit 7 reads 0.
- R3: Register address 1 (control 1) holds: bit 0 timer 1 enable, bit 1 group enable, bit 4 timer 1 flag (set by `tmr1_ovf_i`), and bit 5 a read-only group-pending bit. The other bits read 0.
- R4: Register address 2 (group register) holds sub-enables in bits 0..2 and sub-flags in bits 4..6, for the third timer, time base and real-time flag (`grp_evt_i[0..2]`). The group request is the OR of the sub-flags whose sub-enable is set. Taking the group interrupt leaves the sub-flags unchanged.
- R5: An interrupt is taken only when its flag and enable are set, the master enable is set, and `stack_full_i` is low in that cycle. While `stack_full_i` is high the request stays pending.
- R6: Taking an interrupt raises `irq_ack_o` for exactly one cycle, with `irq_vec_o` valid in that cycle. In the same edge it clears the taken source's flag and the master enable.
- R7: Priority and vectors are fixed: external 0 = 04H, external 1 = 08H, timer 0 = 0CH, timer 1 = 10H, group = 14H. External requests win over simultaneous internal ones.
- R8: A register write loads enables and flags from the written data. A hardware event in the same cycle as a write that clears its flag leaves the flag set.
- R9: After synchronous reset all registers read 0, `irq_ack_o` is 0 and the pins are treated as idle high.
- R10: A read returns the addressed register on `reg_rdata_o` one cycle after `reg_rd_i`. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n_i | input | 2 | Active-low external request pins |
| tmr0_ovf_i | input | 1 | Timer 0 overflow strobe |
| tmr1_ovf_i | input | 1 | Timer 1 overflow strobe |
| grp_evt_i | input | 3 | Group events: third timer, time base, real-time flag |
| stack_full_i | input | 1 | Core call stack is full |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge |
| irq_vec_o | output | 8 | Vector address of the taken interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a hardware flag set and a software register write. The bench provokes this by pulsing the timer 1 strobe in the same cycle as a write that clears that flag, then reads the flag back as set. The second pair is two sources competing in one arbitration cycle. The bench arranges this by loading several pending flags while the master enable is off, then turning the master enable on. A queue of expected vectors is filled in priority order, and each acknowledge must pop the matching entry. An acknowledge that arrives while stack-full is held high finds the queue empty and is reported as a failure.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = 8;
  localparam int N_EXT   = 2;
  localparam int N_GRP   = 3;
  localparam int N_FLAG  = 4;           // sources with their own flag
  localparam int N_SRC   = N_FLAG + 1;  // plus the group request
  localparam int VEC_STEP = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTL0 = 2'd0,
    SEL_CTL1 = 2'd1,
    SEL_GRP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    return VEC_W'((idx + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        last_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_n[g]};
        last_q <= sync_q[STAGES-1];
      end
    end

    assign fall[g] = last_q & ~sync_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      fall[g] |=> !fall[g]); // R1
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_FLAG-1:0] hw_set,
  input  logic [N_GRP-1:0]  grp_evt,
  input  logic              take_valid,
  input  logic [N_FLAG-1:0] take_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              gen,
  output logic [N_SRC-1:0]  pend
);
  logic [N_SRC-1:0]  en_q;
  logic [N_FLAG-1:0] flag_q;
  logic [N_GRP-1:0]  gen_en_q;
  logic [N_GRP-1:0]  grp_flag_q;
  logic              gen_q;
  logic              wr0, wr1, wr2;
  logic [N_FLAG-1:0] sw_we;
  logic [N_FLAG-1:0] sw_val;
  logic              grp_any;

  assign wr0 = wr_en && (addr == SEL_CTL0);
  assign wr1 = wr_en && (addr == SEL_CTL1);
  assign wr2 = wr_en && (addr == SEL_GRP);

  // flag order: 0 ext0, 1 ext1, 2 timer0, 3 timer1
  assign sw_we  = {wr1, wr0, wr0, wr0};
  assign sw_val = {wdata[4], wdata[6], wdata[5], wdata[4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < N_FLAG; i++) begin
        if (hw_set[i])       flag_q[i] <= 1'b1;
        else if (take_clr[i]) flag_q[i] <= 1'b0;
        else if (sw_we[i])   flag_q[i] <= sw_val[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      if (wr0) en_q[2:0] <= wdata[3:1];
      if (wr1) en_q[4:3] <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= 1'b0;
    end else if (take_valid) begin
      gen_q <= 1'b0;
    end else if (wr0) begin
      gen_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en_q   <= '0;
      grp_flag_q <= '0;
    end else begin
      if (wr2) gen_en_q <= wdata[N_GRP-1:0];
      for (int j = 0; j < N_GRP; j++) begin
        if (grp_evt[j])  grp_flag_q[j] <= 1'b1;
        else if (wr2)    grp_flag_q[j] <= wdata[4+j];
      end
    end
  end

  assign grp_any = |(grp_flag_q & gen_en_q);
  assign gen     = gen_q;
  assign pend    = {grp_any & en_q[4], flag_q & en_q[3:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        SEL_CTL0: rdata <= {1'b0, flag_q[2:0], en_q[2:0], gen_q};
        SEL_CTL1: rdata <= {2'b00, grp_any, flag_q[3], 2'b00, en_q[4:3]};
        SEL_GRP:  rdata <= {1'b0, grp_flag_q, 1'b0, gen_en_q};
        default:  rdata <= '0;
      endcase
    end
  end

  AST_GEN_DROPS: assert property (@(posedge clk) disable iff (rst)
    take_valid |=> !gen_q); // R6

  for (genvar g = 0; g < N_FLAG; g++) begin : g_chk
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      hw_set[g] |=> flag_q[g]); // R8
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  input  logic             gen,
  input  logic             stack_full,
  output logic             take_valid,
  output logic [N_SRC-1:0] take_oh,
  output logic             ack,
  output logic [VEC_W-1:0] vec
);
  logic [N_SRC-1:0] sel_oh;
  logic [VEC_W-1:0] sel_vec;

  always_comb begin
    sel_oh  = '0;
    sel_vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        sel_vec   = src_vector(i);
      end
    end
  end

  assign take_valid = gen && (|pend) && !stack_full;
  assign take_oh    = take_valid ? sel_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      vec <= '0;
    end else begin
      ack <= take_valid;
      if (take_valid) vec <= sel_vec;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R6
  AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(stack_full)); // R5
  AST_NEEDS_GEN: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(gen)); // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_oh)); // R7
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ack |-> (vec[1:0] == 2'b00 && vec != '0)); // R7
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_irq_n_i,
  input  logic              tmr0_ovf_i,
  input  logic              tmr1_ovf_i,
  input  logic [N_GRP-1:0]  grp_evt_i,
  input  logic              stack_full_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_ack_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic [N_EXT-1:0]  ext_fall;
  logic [N_FLAG-1:0] hw_set;
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  take_oh;
  logic              take_valid;
  logic              gen;

  irq_edge_sync #(.N(N_EXT), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (ext_irq_n_i),
    .fall  (ext_fall)
  );

  assign hw_set = {tmr1_ovf_i, tmr0_ovf_i, ext_fall};

  irq_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_i),
    .rd_en      (reg_rd_i),
    .addr       (reg_addr_i),
    .wdata      (reg_wdata_i),
    .hw_set     (hw_set),
    .grp_evt    (grp_evt_i),
    .take_valid (take_valid),
    .take_clr   (take_oh[N_FLAG-1:0]),
    .rdata      (reg_rdata_o),
    .gen        (gen),
    .pend       (pend)
  );

  irq_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend),
    .gen        (gen),
    .stack_full (stack_full_i),
    .take_valid (take_valid),
    .take_oh    (take_oh),
    .ack        (irq_ack_o),
    .vec        (irq_vec_o)
  );

  AST_ACK_CLEARS_GEN: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> !gen); // R6
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_irq_n_i = 2'b11;
  logic       tmr0_ovf_i = 1'b0;
  logic       tmr1_ovf_i = 1'b0;
  logic [2:0] grp_evt_i = 3'b000;
  logic       stack_full_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_ack_o;
  logic [7:0] irq_vec_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_irq_n_i(ext_irq_n_i),
    .tmr0_ovf_i(tmr0_ovf_i), .tmr1_ovf_i(tmr1_ovf_i), .grp_evt_i(grp_evt_i),
    .stack_full_i(stack_full_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_ack_o(irq_ack_o), .irq_vec_o(irq_vec_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: every acknowledge pops one expected vector
  always @(negedge clk) begin
    if (!rst && irq_ack_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5/R7: unexpected ack actual %02h expected none", irq_vec_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (irq_vec_o !== e) begin
          errors++;
          $display("FAIL R7: vector actual %02h expected %02h", irq_vec_o, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    check("R6 queue drained", 8'(exp_q.size()), 8'd0);
    exp_q.delete();
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R9 / R10 reset state
    check("R9 ack after reset", {7'd0, irq_ack_o}, 8'd0);
    rd_check(2'd0, 8'h00, "R9 ctl0 reset");
    rd_check(2'd1, 8'h00, "R9 ctl1 reset");
    rd_check(2'd2, 8'h00, "R9 grp reset");
    rd_check(2'd3, 8'h00, "R10 unused address");

    // R1: falling edge sets flag, held low does not re-set, rise sets nothing
    ext_irq_n_i[0] = 1'b0;
    idle(5);
    rd_check(2'd0, 8'h10, "R1 ext0 edge sets flag");
    wr(2'd0, 8'h00);
    idle(6);
    rd_check(2'd0, 8'h00, "R1 held low no re-set");
    ext_irq_n_i[0] = 1'b1;
    idle(6);
    rd_check(2'd0, 8'h00, "R1 rising edge ignored");

    // R5/R6: take ext0 with master enable
    wr(2'd0, 8'h03);
    exp_q.push_back(8'h04);
    ext_irq_n_i[0] = 1'b0;
    idle(8);
    drain();
    rd_check(2'd0, 8'h02, "R6 flag and master enable cleared");
    ext_irq_n_i[0] = 1'b1;
    idle(4);

    // R7: external beats simultaneous timer
    wr(2'd0, 8'h0A);
    @(negedge clk);
    ext_irq_n_i[0] = 1'b0; tmr0_ovf_i = 1'b1;
    @(negedge clk);
    tmr0_ovf_i = 1'b0;
    idle(5);
    rd_check(2'd0, 8'h5A, "R2 ext0 and timer0 flags pending");
    exp_q.push_back(8'h04);
    wr(2'd0, 8'h5B);
    idle(3);
    drain();
    rd_check(2'd0, 8'h4A, "R7 external served first");
    exp_q.push_back(8'h0C);
    wr(2'd0, 8'h4B);
    idle(3);
    drain();
    ext_irq_n_i[0] = 1'b1;

    // R2/R8: software-set flags, ext1 beats timer0
    wr(2'd0, 8'h6C);
    rd_check(2'd0, 8'h6C, "R8 software sets flags");
    exp_q.push_back(8'h08);
    wr(2'd0, 8'h6D);
    idle(3);
    drain();
    rd_check(2'd0, 8'h4C, "R7 ext1 taken before timer0");
    exp_q.push_back(8'h0C);
    wr(2'd0, 8'h4D);
    idle(3);
    drain();
    rd_check(2'd0, 8'h0C, "R6 timer0 flag cleared");

    // R5: stack full holds off timer1
    stack_full_i = 1'b1;
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h0D);
    idle(6);
    rd_check(2'd1, 8'h11, "R5 pending kept while stack full");
    exp_q.push_back(8'h10);
    stack_full_i = 1'b0;
    idle(3);
    drain();
    rd_check(2'd1, 8'h01, "R3 timer1 flag cleared on take");

    // R4: group sources
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h03);
    @(negedge clk); grp_evt_i = 3'b010;
    @(negedge clk); grp_evt_i = 3'b000;
    rd_check(2'd2, 8'h21, "R4 disabled sub-flag set");
    rd_check(2'd1, 8'h03, "R4 disabled sub-event not pending");
    @(negedge clk); grp_evt_i = 3'b001;
    @(negedge clk); grp_evt_i = 3'b000;
    rd_check(2'd2, 8'h31, "R4 enabled sub-flag set");
    rd_check(2'd1, 8'h23, "R3 group pending bit");
    exp_q.push_back(8'h14);
    wr(2'd0, 8'h0D);
    idle(3);
    drain();
    rd_check(2'd2, 8'h31, "R4 sub-flags kept after take");
    rd_check(2'd0, 8'h0C, "R6 master enable cleared by group take");

    // R8: hardware event beats simultaneous software clear
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 8'h03; tmr1_ovf_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0; tmr1_ovf_i = 1'b0;
    rd_check(2'd1, 8'h33, "R8 hw set wins over sw clear");

    idle(4);
    check("R6 no stray vectors", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule